// File: doc/BRIEF.md
# Core Idle State Sequencer

This block is a per-core state machine that takes one processor core from normal execution into one of two deep idle levels and back again. A sleep request arrives as a single-cycle pulse, either from the decoder of an idle-level I/O read or from the decoder of a monitor-wait instruction. For each of the two levels there is one pulse input per source. Before the core may stop, the sequencer asks the cache controller to write its first-level caches back into the shared second-level cache, and it waits for the controller to confirm. Only then does it gate the core clock.

While the core sleeps, bus snoops and cacheable traffic from the sibling core are tolerated without waking it. This is safe because the first-level caches are already empty. Six wake events bring the core back: a monitor event, a system-management interrupt, an INIT request, NMI, INTR and a bus interrupt message. They are ranked, and the highest-ranked one is recorded as the wake cause. The two sleep levels behave identically inside the core. They differ only in the 2-bit code reported to the package-level coordinator.

A flag marking an armed address monitor is kept by the block, and it survives sleep. A synchronous active-low reset returns everything to the initial state from any state.

Top module: `core_idle_seq`

## Requirements
- R1: In the active state, a pulse on `io_lvl3_req` or `mwait_c3_req` starts entry toward the level-3 sleep, and a pulse on `io_lvl4_req` or `mwait_c4_req` starts entry toward the level-4 sleep. If both levels are requested in the same cycle, level 4 is chosen. The cycle after the request, `flush_req` is 1.
- R2: `flush_req` stays at 1 until the first cycle in which `flush_done` is sampled high. In the next cycle the core is asleep at the chosen level, and `flush_req` has returned to 0. Sleep is never entered without a preceding flush completion.
- R3: `clk_gate_en` is 1 exactly while the core is asleep (level 3 or level 4), and 0 while it is active or flushing.
- R4: `pkg_state` reports 2'b00 while active or flushing, 2'b10 in level-3 sleep and 2'b11 in level-4 sleep. The code 2'b01 is reserved and never produced.
- R5: While the core is asleep, `snoop_hit` and `sibling_cacheable` have no effect: with no wake event the core stays asleep at the same level.
- R6: While the core is asleep, any wake event puts the core back in the active state in the next cycle (`pkg_state`=00, `clk_gate_en`=0).
- R7: On each exit from sleep or from an aborted flush, `wake_cause` is loaded with the code of the highest-ranked wake event. The codes, from highest rank to lowest, are INIT=1, SMI=2, NMI=3, bus message=4, INTR=5, monitor=6. Reset sets `wake_cause` to 0. The value is held until the next exit.
- R8: A wake event seen while flushing does not stop `flush_req`. When `flush_done` arrives, the core returns to the active state instead of sleeping, and `wake_cause` takes the code of the first wake event seen during that flush.
- R9: A sleep request that arrives while flushing or asleep is ignored. A wake event that arrives in the active state is ignored and leaves `wake_cause` unchanged.
- R10: `monitor_armed` is set by a pulse on `monitor_arm` and cleared by a pulse on `monitor_clr`; clear wins when both arrive together. Sleep entry, sleep residency and wake-up, including a monitor wake event, leave it unchanged.
- R11: With `rst_n` sampled low at a clock edge, all outputs are 0 in the following cycle, whatever the state was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock before gating |
| rst_n | input | 1 | Synchronous active-low reset |
| io_lvl3_req | input | 1 | Level-3 sleep request from the idle I/O read decoder (pulse) |
| mwait_c3_req | input | 1 | Level-3 sleep request from the monitor-wait decoder (pulse) |
| io_lvl4_req | input | 1 | Level-4 sleep request from the idle I/O read decoder (pulse) |
| mwait_c4_req | input | 1 | Level-4 sleep request from the monitor-wait decoder (pulse) |
| flush_done | input | 1 | First-level cache write-back complete |
| snoop_hit | input | 1 | Bus snoop observed (never wakes the core) |
| sibling_cacheable | input | 1 | Sibling core cacheable access (never wakes the core) |
| wake_monitor | input | 1 | Monitor event wake |
| wake_smi | input | 1 | System-management interrupt wake |
| wake_init | input | 1 | INIT request wake |
| wake_nmi | input | 1 | NMI local interrupt wake |
| wake_intr | input | 1 | INTR local interrupt wake |
| wake_bus_msg | input | 1 | Interrupt message from the bus |
| monitor_arm | input | 1 | Arms the address monitor flag (pulse) |
| monitor_clr | input | 1 | Disarms the address monitor flag (pulse) |
| flush_req | output | 1 | Request to write back the first-level caches |
| clk_gate_en | output | 1 | Stop the core clocks |
| pkg_state | output | 2 | Idle level reported to the package coordinator |
| wake_cause | output | 4 | Code of the event that ended the last sleep attempt |
| monitor_armed | output | 1 | Address monitor is armed |

## Verification
Every output is a decode of a register, so each result is due exactly one clock after the edge that samples the stimulus. This holds for a request, a flush completion, a wake event, a monitor pulse and reset alike. The bench changes inputs on the falling edge. Its behavioural model advances on the same rising edge as the design. Every output is compared 2 ns after that rising edge, and the directed checks sample on the following falling edge, so each comparison falls in the cycle in which the result is due. Aborted flushes, simultaneous requests and simultaneous wakes, together with long random runs, exercise the ordering cases.

// File: rtl/cis_pkg.sv
// Shared types for the core idle state sequencer.
// Assumes: state encodings are private; only the package code leaves the block.
package cis_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_SLP3   = 2'd2,
        ST_SLP4   = 2'd3
    } core_st_e;

    // Codes seen by the package coordinator.
    localparam logic [1:0] PKG_RUN     = 2'b00;
    localparam logic [1:0] PKG_SHALLOW = 2'b01;  // reserved, never produced here
    localparam logic [1:0] PKG_SLP3    = 2'b10;
    localparam logic [1:0] PKG_SLP4    = 2'b11;

    // Maps an internal state to the coordinator code.
    function automatic logic [1:0] pkg_code(input core_st_e st);
        case (st)
            ST_SLP3: pkg_code = PKG_SLP3;
            ST_SLP4: pkg_code = PKG_SLP4;
            default: pkg_code = PKG_RUN;
        endcase
    endfunction

endpackage

// File: rtl/cis_entry_decode.sv
// Merges the per-source sleep request pulses into one start strobe and a
// depth select. Assumes requests are single-cycle pulses; they only count
// while enable (active state) is high. The deeper level wins a tie.
module cis_entry_decode #(
    parameter int NUM_SRC = 2
) (
    input  logic               enable,
    input  logic [NUM_SRC-1:0] lvl3_src,
    input  logic [NUM_SRC-1:0] lvl4_src,
    output logic               start,
    output logic               deep
);
    // Combine sources and qualify with the enable.
    always_comb begin
        deep  = enable & (|lvl4_src);
        start = enable & ((|lvl3_src) | (|lvl4_src));
    end
endmodule

// File: rtl/cis_wake_prio.sv
// Ranks the activity lines and returns the code of the highest-ranked line
// that is allowed to wake the core. Line i carries code i+1; line 0 ranks
// highest. WAKE_MASK selects which lines are wake events; the others are
// observed but can never wake the core.
module cis_wake_prio #(
    parameter int                 NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WAKE_MASK = '1,
    localparam int                CODE_W    = $clog2(NUM_LINES + 1)
) (
    input  logic [NUM_LINES-1:0] lines,
    output logic                 any,
    output logic [CODE_W-1:0]    code
);
    logic [NUM_LINES-1:0] qual;
    logic [NUM_LINES-1:0] hit;

    // Drop lines that are not wake events.
    always_comb qual = lines & WAKE_MASK;

    // One-hot winner: a line hits only if no higher-ranked line is present.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_rank
            if (gi == 0) begin : g_top
                assign hit[gi] = qual[gi];
            end else begin : g_rest
                assign hit[gi] = qual[gi] & ~(|qual[gi-1:0]);
            end
        end
    endgenerate

    // Encode the winner.
    always_comb begin
        any  = |qual;
        code = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (hit[i]) code = code | CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/cis_monitor_flag.sv
// Holds the armed state of the address monitor. Assumes arm and clear are
// pulses; clear wins. Sleep state has no path into this register.
module cis_monitor_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic armed
);
    // Armed flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)   armed <= 1'b0;
        else if (clr) armed <= 1'b0;
        else if (arm) armed <= 1'b1;
    end
endmodule

// File: rtl/core_idle_seq.sv
// Core idle state sequencer: takes one core from active through a cache
// flush handshake into level-3 or level-4 sleep, gates its clock, and
// returns it to active on a ranked wake event. Snoops and sibling traffic
// are routed to the ranker but masked, so they never wake the core.
// Assumes: request and wake inputs are synchronous to clk; flush_done is
// only meaningful while flush_req is high.
module core_idle_seq
    import cis_pkg::*;
#(
    parameter int NUM_REQ_SRC = 2,
    parameter int NUM_WAKE    = 6,
    parameter int NUM_QUIET   = 2,
    localparam int NUM_LINES  = NUM_WAKE + NUM_QUIET,
    localparam int CAUSE_W    = $clog2(NUM_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_lvl3_req,
    input  logic               mwait_c3_req,
    input  logic               io_lvl4_req,
    input  logic               mwait_c4_req,
    input  logic               flush_done,
    input  logic               snoop_hit,
    input  logic               sibling_cacheable,
    input  logic               wake_monitor,
    input  logic               wake_smi,
    input  logic               wake_init,
    input  logic               wake_nmi,
    input  logic               wake_intr,
    input  logic               wake_bus_msg,
    input  logic               monitor_arm,
    input  logic               monitor_clr,
    output logic               flush_req,
    output logic               clk_gate_en,
    output logic [1:0]         pkg_state,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic               monitor_armed
);
    localparam logic [NUM_LINES-1:0] WAKE_MASK =
        {{NUM_QUIET{1'b0}}, {NUM_WAKE{1'b1}}};

    core_st_e             state;
    core_st_e             target;
    logic [CAUSE_W-1:0]   pend_cause;
    logic                 start, deep;
    logic                 wake_any;
    logic [CAUSE_W-1:0]   wake_code;
    logic [NUM_LINES-1:0] lines;

    // Activity lines in rank order; the last two are never wake events.
    always_comb begin
        lines = {sibling_cacheable, snoop_hit, wake_monitor, wake_intr,
                 wake_bus_msg, wake_nmi, wake_smi, wake_init};
    end

    cis_entry_decode #(.NUM_SRC(NUM_REQ_SRC)) u_entry (
        .enable   (state == ST_ACTIVE),
        .lvl3_src ({io_lvl3_req, mwait_c3_req}),
        .lvl4_src ({io_lvl4_req, mwait_c4_req}),
        .start    (start),
        .deep     (deep)
    );

    cis_wake_prio #(.NUM_LINES(NUM_LINES), .WAKE_MASK(WAKE_MASK)) u_prio (
        .lines (lines),
        .any   (wake_any),
        .code  (wake_code)
    );

    cis_monitor_flag u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (monitor_arm),
        .clr   (monitor_clr),
        .armed (monitor_armed)
    );

    // Main sequencer: entry, flush wait with abort capture, sleep, wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_ACTIVE;
            target     <= ST_SLP3;
            pend_cause <= '0;
            wake_cause <= '0;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    if (start) begin
                        state      <= ST_FLUSH;
                        target     <= deep ? ST_SLP4 : ST_SLP3;
                        pend_cause <= '0;
                    end
                end
                ST_FLUSH: begin
                    if (flush_done) begin
                        if (pend_cause != '0) begin
                            state      <= ST_ACTIVE;
                            wake_cause <= pend_cause;
                        end else if (wake_any) begin
                            state      <= ST_ACTIVE;
                            wake_cause <= wake_code;
                        end else begin
                            state <= target;
                        end
                        pend_cause <= '0;
                    end else if (pend_cause == '0 && wake_any) begin
                        pend_cause <= wake_code;
                    end
                end
                ST_SLP3, ST_SLP4: begin
                    if (wake_any) begin
                        state      <= ST_ACTIVE;
                        wake_cause <= wake_code;
                    end
                end
                default: state <= ST_ACTIVE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        flush_req   = (state == ST_FLUSH);
        clk_gate_en = (state == ST_SLP3) || (state == ST_SLP4);
        pkg_state   = pkg_code(state);
    end

endmodule

// File: rtl/cis_checker.sv
// Temporal checks on the sequencer ports; attached to every instance of
// the top module by the bind below. Assumes nothing beyond the port list.
module cis_checker #(
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_done,
    input logic               wake_monitor,
    input logic               wake_smi,
    input logic               wake_init,
    input logic               wake_nmi,
    input logic               wake_intr,
    input logic               wake_bus_msg,
    input logic               monitor_clr,
    input logic               flush_req,
    input logic               clk_gate_en,
    input logic [1:0]         pkg_state,
    input logic [CAUSE_W-1:0] wake_cause,
    input logic               monitor_armed
);
    logic any_wake;

    // Any of the six genuine wake events.
    always_comb any_wake = wake_monitor | wake_smi | wake_init |
                           wake_nmi | wake_intr | wake_bus_msg;

    assert_flush_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_done |=> flush_req);

    assert_sleep_after_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_en) |-> $past(flush_req && flush_done));

    assert_gate_only_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en == pkg_state[1]);

    assert_no_reserved_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_state != 2'b01);

    assert_quiet_stays_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en && !any_wake |=> clk_gate_en && $stable(pkg_state));

    assert_wake_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en && any_wake |=> !clk_gate_en && pkg_state == 2'b00);

    assert_abort_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && flush_done && any_wake |=> !clk_gate_en && !flush_req);

    assert_monitor_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_armed && !monitor_clr |=> monitor_armed);

    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> pkg_state == 2'b00 && !flush_req && !clk_gate_en &&
                   wake_cause == '0 && !monitor_armed);

endmodule

bind core_idle_seq cis_checker #(.CAUSE_W(CAUSE_W)) u_cis_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_done    (flush_done),
    .wake_monitor  (wake_monitor),
    .wake_smi      (wake_smi),
    .wake_init     (wake_init),
    .wake_nmi      (wake_nmi),
    .wake_intr     (wake_intr),
    .wake_bus_msg  (wake_bus_msg),
    .monitor_clr   (monitor_clr),
    .flush_req     (flush_req),
    .clk_gate_en   (clk_gate_en),
    .pkg_state     (pkg_state),
    .wake_cause    (wake_cause),
    .monitor_armed (monitor_armed)
);

// File: tb/tb_core_idle_seq.sv
// Bench for the core idle state sequencer: a behavioural model advanced on
// every rising edge and compared 2 ns later, plus directed checks.
module tb_core_idle_seq;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n = 1'b0;
    logic io_lvl3_req = 0, mwait_c3_req = 0, io_lvl4_req = 0, mwait_c4_req = 0;
    logic flush_done = 0, snoop_hit = 0, sibling_cacheable = 0;
    logic wake_monitor = 0, wake_smi = 0, wake_init = 0, wake_nmi = 0;
    logic wake_intr = 0, wake_bus_msg = 0, monitor_arm = 0, monitor_clr = 0;
    logic       flush_req, clk_gate_en, monitor_armed;
    logic [1:0] pkg_state;
    logic [3:0] wake_cause;

    core_idle_seq dut (
        .clk(clk), .rst_n(rst_n),
        .io_lvl3_req(io_lvl3_req), .mwait_c3_req(mwait_c3_req),
        .io_lvl4_req(io_lvl4_req), .mwait_c4_req(mwait_c4_req),
        .flush_done(flush_done), .snoop_hit(snoop_hit),
        .sibling_cacheable(sibling_cacheable),
        .wake_monitor(wake_monitor), .wake_smi(wake_smi), .wake_init(wake_init),
        .wake_nmi(wake_nmi), .wake_intr(wake_intr), .wake_bus_msg(wake_bus_msg),
        .monitor_arm(monitor_arm), .monitor_clr(monitor_clr),
        .flush_req(flush_req), .clk_gate_en(clk_gate_en), .pkg_state(pkg_state),
        .wake_cause(wake_cause), .monitor_armed(monitor_armed)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model state: 0 active, 1 flushing, 3 level-3 sleep, 4 level-4 sleep.
    int m_st = 0, m_tgt = 3, m_pend = 0, m_cause = 0, m_arm = 0;

    function automatic int rank_code();
        if (wake_init)    return 1;
        if (wake_smi)     return 2;
        if (wake_nmi)     return 3;
        if (wake_bus_msg) return 4;
        if (wake_intr)    return 5;
        if (wake_monitor) return 6;
        return 0;
    endfunction

    // Advance the model on each rising edge, then compare every output.
    always @(posedge clk) begin
        int w;
        int p;
        w = rank_code();
        if (!rst_n) begin
            m_st = 0; m_tgt = 3; m_pend = 0; m_cause = 0; m_arm = 0;
        end else begin
            if (monitor_clr) m_arm = 0;
            else if (monitor_arm) m_arm = 1;
            if (m_st == 0) begin
                if (io_lvl4_req || mwait_c4_req) begin m_st = 1; m_tgt = 4; m_pend = 0; end
                else if (io_lvl3_req || mwait_c3_req) begin m_st = 1; m_tgt = 3; m_pend = 0; end
            end else if (m_st == 1) begin
                p = (m_pend != 0) ? m_pend : w;
                if (flush_done) begin
                    if (p != 0) begin m_st = 0; m_cause = p; end
                    else m_st = m_tgt;
                    m_pend = 0;
                end else m_pend = p;
            end else if (w != 0) begin
                m_st = 0; m_cause = w;
            end
        end
        #2;
        chk("R4 pkg_state", 8'(pkg_state), 8'(m_st == 3 ? 2 : (m_st == 4 ? 3 : 0)));
        chk("R3 clk_gate_en", 8'(clk_gate_en), 8'(m_st >= 3));
        chk("R2 flush_req", 8'(flush_req), 8'(m_st == 1));
        chk("R7 wake_cause", 8'(wake_cause), 8'(m_cause));
        chk("R10 monitor_armed", 8'(monitor_armed), 8'(m_arm));
    end

    task automatic clear_pulses();
        io_lvl3_req = 0; mwait_c3_req = 0; io_lvl4_req = 0; mwait_c4_req = 0;
        flush_done = 0; wake_monitor = 0; wake_smi = 0; wake_init = 0;
        wake_nmi = 0; wake_intr = 0; wake_bus_msg = 0;
        monitor_arm = 0; monitor_clr = 0;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Finish one pulse cycle: the output is due at this falling edge.
    task automatic end_pulse();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        step(3);
        chk("R11 reset pkg_state", 8'(pkg_state), 8'd0);
        chk("R11 reset wake_cause", 8'(wake_cause), 8'd0);
        rst_n = 1;
        step(1);

        // Level-3 entry through the I/O read source.
        io_lvl3_req = 1; end_pulse();
        chk("R1 flush_req after level-3 request", 8'(flush_req), 8'd1);
        chk("R1 pkg_state while flushing", 8'(pkg_state), 8'd0);
        step(3);
        chk("R2 flush_req held", 8'(flush_req), 8'd1);
        flush_done = 1; end_pulse();
        chk("R2 level-3 reached", 8'(pkg_state), 8'd2);
        chk("R3 clock gated", 8'(clk_gate_en), 8'd1);
        snoop_hit = 1; sibling_cacheable = 1; step(4);
        snoop_hit = 0; sibling_cacheable = 0;
        chk("R5 still asleep after snoop", 8'(pkg_state), 8'd2);
        io_lvl4_req = 1; end_pulse();
        chk("R9 request while asleep ignored", 8'(pkg_state), 8'd2);
        wake_intr = 1; end_pulse();
        chk("R6 woken by INTR", 8'(pkg_state), 8'd0);
        chk("R7 INTR cause", 8'(wake_cause), 8'd5);

        // Both levels at once through the instruction sources: level 4 wins.
        mwait_c3_req = 1; mwait_c4_req = 1; end_pulse();
        io_lvl3_req = 1; end_pulse();
        chk("R9 request while flushing ignored", 8'(flush_req), 8'd1);
        flush_done = 1; end_pulse();
        chk("R1 tie chooses level 4", 8'(pkg_state), 8'd3);
        wake_monitor = 1; wake_smi = 1; end_pulse();
        chk("R7 SMI outranks monitor", 8'(wake_cause), 8'd2);

        // Wake during flush aborts the entry.
        io_lvl4_req = 1; end_pulse();
        wake_nmi = 1; end_pulse();
        wake_bus_msg = 1; end_pulse();
        chk("R8 flush continues after wake", 8'(flush_req), 8'd1);
        flush_done = 1; end_pulse();
        chk("R8 aborted to active", 8'(pkg_state), 8'd0);
        chk("R8 first wake recorded", 8'(wake_cause), 8'd3);

        // Wake in active is ignored.
        wake_init = 1; end_pulse();
        chk("R9 wake in active keeps cause", 8'(wake_cause), 8'd3);

        // Monitor flag survives sleep and a monitor wake.
        monitor_arm = 1; end_pulse();
        mwait_c3_req = 1; end_pulse();
        flush_done = 1; end_pulse();
        step(5);
        chk("R10 armed during sleep", 8'(monitor_armed), 8'd1);
        wake_monitor = 1; end_pulse();
        chk("R10 armed after monitor wake", 8'(monitor_armed), 8'd1);
        chk("R7 monitor cause", 8'(wake_cause), 8'd6);
        monitor_arm = 1; monitor_clr = 1; end_pulse();
        chk("R10 clear wins", 8'(monitor_armed), 8'd0);

        // Reset in the middle of sleep.
        io_lvl4_req = 1; end_pulse();
        flush_done = 1; end_pulse();
        chk("R2 level-4 reached", 8'(pkg_state), 8'd3);
        rst_n = 0; step(1); rst_n = 1;
        chk("R11 reset from sleep", 8'(pkg_state), 8'd0);
        chk("R11 reset clears cause", 8'(wake_cause), 8'd0);

        // Random traffic, compared by the model on every clock.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            clear_pulses();
            io_lvl3_req   = ($urandom_range(0, 15) == 0);
            mwait_c3_req  = ($urandom_range(0, 15) == 0);
            io_lvl4_req   = ($urandom_range(0, 15) == 0);
            mwait_c4_req  = ($urandom_range(0, 15) == 0);
            flush_done    = ($urandom_range(0, 3) == 0);
            snoop_hit         = ($urandom_range(0, 2) == 0);
            sibling_cacheable = ($urandom_range(0, 2) == 0);
            wake_init     = ($urandom_range(0, 40) == 0);
            wake_smi      = ($urandom_range(0, 40) == 0);
            wake_nmi      = ($urandom_range(0, 40) == 0);
            wake_bus_msg  = ($urandom_range(0, 40) == 0);
            wake_intr     = ($urandom_range(0, 40) == 0);
            wake_monitor  = ($urandom_range(0, 40) == 0);
            monitor_arm   = ($urandom_range(0, 20) == 0);
            monitor_clr   = ($urandom_range(0, 30) == 0);
        end
        @(negedge clk);
        clear_pulses();
        snoop_hit = 0; sibling_cacheable = 0;
        step(3);
        summary();
        $finish;
    end

endmodule